// File: doc/BRIEF.md
# Two-Wire Receive-Only DAC Code Register

This block is the digital front end of a one- or two-channel 8-bit converter that is programmed over a two-wire serial bus. It never initiates a transfer and never returns data. It oversamples the clock and data lines with a fast system clock, recognises bus start and stop events, and checks the first byte of each transfer against its own slave address. Part of that address is fixed and the rest comes from strap pins. After a match it accepts a stream of command/data byte pairs. Each command picks a channel and can request a hold, a transfer of all staged codes or a clear. Each data byte is written into the chosen channel's staging latch. The code an analog stage would convert is held in a second, output latch per channel.

The only drive onto the bus is an open-drain pull-low enable, used to acknowledge bytes. The surrounding pad logic ties the pull enable to the data line, so the value the block receives is the wired-AND of the master and its own pull.

Top module: `tw_dac_port`

## Requirements
- R1: After reset every output code is 0x00 and the SDA pull enable is low.
- R2: The first byte after a START is matched as bits 7:5 = 010, bits 4:1 = the address pins (pin 3 in bit 4 down to pin 0 in bit 1), and bit 0 (read/write) = 0. A match is acknowledged. A mismatch or bit 0 = 1 gets no acknowledge, and later bytes change no code until the next START.
- R3: For a matched address byte and every command or data byte after it, the SDA pull enable is high during the ninth SCL high phase and low again before the next SCL high phase.
- R4: Command bit 0 selects the channel: 0 is channel 0 on dac_code_o[7:0] and 1 is channel 1 on dac_code_o[15:8]. The data byte that follows is loaded into that channel's staging latch and then copied to its output latch.
- R5: When command bit 3 is set, the data byte is only staged and the output code stays unchanged.
- R6: Command bit 1 copies every staging latch to its output latch when the command byte completes, including a lone command byte just before STOP.
- R7: Command bit 4 clears the staging and output latches of every channel to zero when the command byte completes. The paired data byte is then applied as usual.
- R8: Any number of command/data pairs may follow one address byte within a single transfer, and each one is applied.
- R9: A STOP in the middle of a byte discards the partial byte and changes no code.
- R10: A START at any point, including inside a byte or after an ignored address, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND with own pull) |
| addr_pin_i | input | ADDR_PINS (4) | Strapped low bits of the slave address |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| dac_code_o | output | NUM_CH*8 (16) | Output-latch codes, channel 0 in the low byte |

## Verification
The hardest situations to reach from the ports are bus events that land inside a byte: a STOP or a repeated START after only a few data bits, and a START that follows an address the block has chosen to ignore. The bench drives the two lines bit by bit with its own bus tasks. It can stop after any number of bits and then issue a stop or start, and afterwards it confirms that the codes are unchanged or that the new transfer takes effect. The hold and transfer bits are combined across two transfers, so the staging latch can be observed through the outputs alone.

// File: rtl/tw_dac_pkg.sv
package tw_dac_pkg;

   localparam int BYTE_W = 8;

   // command byte field positions
   localparam int CMD_SEL_BIT  = 0;
   localparam int CMD_XFER_BIT = 1;
   localparam int CMD_HOLD_BIT = 3;
   localparam int CMD_CLR_BIT  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_DATA,
      ST_SKIP
   } tw_state_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_s;
   logic                   scl_d;
   logic                   sda_d;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tw_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_s     = scl_sh[SYNC_STAGES-1];
   assign sda_s     = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match #(
   parameter int         ADDR_PINS = 4,
   parameter logic [6:0] ADDR_BASE = 7'h28
) (
   input  logic [7:0]           addr_byte,
   input  logic [ADDR_PINS-1:0] pins,
   output logic                 match
);

   localparam int FIX_W = 7 - ADDR_PINS;

   logic [6:0] expect_addr;

   generate
      if (ADDR_PINS < 1 || ADDR_PINS > 6) begin : g_bad_pins
         $error("tw_addr_match: ADDR_PINS out of range");
      end
   endgenerate

   assign expect_addr = {ADDR_BASE[6 -: FIX_W], pins};
   assign match       = (addr_byte[7:1] == expect_addr) && !addr_byte[0];

endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
   import tw_dac_pkg::*;
#(
   parameter int         NUM_CH    = 2,
   parameter int         ADDR_PINS = 4,
   parameter logic [6:0] ADDR_BASE = 7'h28
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic                 sda_s,
   input  logic [ADDR_PINS-1:0] addr_pins,
   output logic                 sda_pull,
   output logic                 wr_en,
   output logic                 wr_ch,
   output logic                 wr_hold,
   output logic [BYTE_W-1:0]    wr_data,
   output logic                 xfer_all,
   output logic                 clr_all
);

   localparam logic [3:0] LAST_BIT = 4'd7;
   localparam logic [3:0] ACK_SLOT = 4'd8;

   tw_state_e         state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-2:0] shreg;
   logic [BYTE_W-1:0] byte_next;
   logic              ack_due;
   logic              cmd_sel;
   logic              cmd_hold;
   logic              addr_ok;

   assign byte_next = {shreg, sda_s};

   tw_addr_match #(
      .ADDR_PINS(ADDR_PINS),
      .ADDR_BASE(ADDR_BASE)
   ) u_match (
      .addr_byte(byte_next),
      .pins     (addr_pins),
      .match    (addr_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         ack_due  <= 1'b0;
         sda_pull <= 1'b0;
         cmd_sel  <= 1'b0;
         cmd_hold <= 1'b0;
         wr_en    <= 1'b0;
         wr_ch    <= 1'b0;
         wr_hold  <= 1'b0;
         wr_data  <= '0;
         xfer_all <= 1'b0;
         clr_all  <= 1'b0;
      end else begin
         wr_en    <= 1'b0;
         xfer_all <= 1'b0;
         clr_all  <= 1'b0;
         if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            ack_due  <= 1'b0;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            ack_due  <= 1'b0;
            sda_pull <= 1'b0;
         end else begin
            if (scl_rise && state != ST_IDLE && state != ST_SKIP) begin
               if (bit_cnt == ACK_SLOT) begin
                  bit_cnt <= '0;
               end else begin
                  shreg   <= byte_next[BYTE_W-2:0];
                  bit_cnt <= bit_cnt + 4'd1;
                  if (bit_cnt == LAST_BIT) begin
                     unique case (state)
                        ST_ADDR: begin
                           if (addr_ok) begin
                              state   <= ST_CMD;
                              ack_due <= 1'b1;
                           end else begin
                              state   <= ST_SKIP;
                           end
                        end
                        ST_CMD: begin
                           cmd_sel  <= (NUM_CH > 1) ? byte_next[CMD_SEL_BIT] : 1'b0;
                           cmd_hold <= byte_next[CMD_HOLD_BIT];
                           clr_all  <= byte_next[CMD_CLR_BIT];
                           xfer_all <= byte_next[CMD_XFER_BIT] & ~byte_next[CMD_CLR_BIT];
                           ack_due  <= 1'b1;
                           state    <= ST_DATA;
                        end
                        ST_DATA: begin
                           wr_en   <= 1'b1;
                           wr_ch   <= cmd_sel;
                           wr_hold <= cmd_hold;
                           wr_data <= byte_next;
                           ack_due <= 1'b1;
                           state   <= ST_CMD;
                        end
                        default: state <= ST_IDLE;
                     endcase
                  end
               end
            end
            if (scl_fall) begin
               if (bit_cnt == ACK_SLOT && ack_due) begin
                  sda_pull <= 1'b1;
                  ack_due  <= 1'b0;
               end else if (bit_cnt == '0) begin
                  sda_pull <= 1'b0;
               end
            end
         end
      end
   end

   // R9
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_pull));

   // R10
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_ADDR && bit_cnt == '0));

   // R3
   pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall));

   // R2
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!sda_pull && !wr_en && !clr_all && !xfer_all));

endmodule

// File: rtl/tw_dac_latch.sv
module tw_dac_latch
   import tw_dac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic              hold,
   input  logic              xfer,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] code_o
);

   logic [BYTE_W-1:0] stage_q;
   logic              push_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         code_o  <= '0;
         push_q  <= 1'b0;
      end else if (clr) begin
         stage_q <= '0;
         code_o  <= '0;
         push_q  <= 1'b0;
      end else begin
         if (ld) begin
            stage_q <= din;
         end
         push_q <= ld & ~hold;
         if (push_q || xfer) begin
            code_o <= stage_q;
         end
      end
   end

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (code_o == '0));

   // R4
   load_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !hold && !clr) |=> ##1 (code_o == $past(din, 2)));

   // R5
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && hold && !clr && !xfer) |=> $stable(code_o));

endmodule

// File: rtl/tw_dac_port.sv
module tw_dac_port
   import tw_dac_pkg::*;
#(
   parameter int         NUM_CH      = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] ADDR_BASE   = 7'h28,
   localparam int        ADDR_PINS   = (NUM_CH == 1) ? 2 : 4,
   localparam int        CODE_W      = NUM_CH * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic [ADDR_PINS-1:0] addr_pin_i,
   output logic                 sda_pull_o,
   output logic [CODE_W-1:0]    dac_code_o
);

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wr_en;
   logic              wr_ch;
   logic              wr_hold;
   logic [BYTE_W-1:0] wr_data;
   logic              xfer_all;
   logic              clr_all;

   generate
      if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
         $error("tw_dac_port: NUM_CH must be 1 or 2");
      end
   endgenerate

   tw_line_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   tw_frame_ctl #(
      .NUM_CH   (NUM_CH),
      .ADDR_PINS(ADDR_PINS),
      .ADDR_BASE(ADDR_BASE)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_s    (sda_s),
      .addr_pins(addr_pin_i),
      .sda_pull (sda_pull_o),
      .wr_en    (wr_en),
      .wr_ch    (wr_ch),
      .wr_hold  (wr_hold),
      .wr_data  (wr_data),
      .xfer_all (xfer_all),
      .clr_all  (clr_all)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tw_dac_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .ld    (wr_en && (int'(wr_ch) == c)),
            .hold  (wr_hold),
            .xfer  (xfer_all),
            .din   (wr_data),
            .code_o(dac_code_o[c*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   // R1
   pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !sda_pull_o) |=> !sda_pull_o);

endmodule

// File: tb/sim_tw_dac_port.sv
module sim_tw_dac_port;

   localparam int Q = 8;
   localparam logic [7:0] ADDR_OK = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [3:0]  pins = 4'b0110;
   logic        sda_pull;
   logic [15:0] codes;
   logic        sda_bus;
   int          nchk = 0;
   int          nbad = 0;

   always #2 clk = ~clk;

   assign sda_bus = m_sda & ~sda_pull;

   tw_dac_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .addr_pin_i(pins),
      .sda_pull_o(sda_pull),
      .dac_code_o(codes)
   );

   // addr, cmd, data, expected ch0, expected ch1, expected ack
   localparam logic [47:0] VEC [0:7] = '{
      48'h4C_00_A5_A5_00_01,
      48'h4C_01_3C_A5_3C_01,
      48'h4E_00_FF_A5_3C_00,
      48'h4D_00_FF_A5_3C_00,
      48'h4C_10_77_77_00_01,
      48'h4C_01_00_77_00_01,
      48'h4C_00_FF_FF_00_01,
      48'h5C_01_EE_FF_00_00
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b;    tick(Q);
      m_scl = 1'b1; tick(Q);
      m_scl = 1'b0; tick(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q/2);
      ack = ~sda_bus;
      tick(Q/2);
      m_scl = 1'b0; tick(Q);
      rel = ~sda_pull;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nbad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      logic a, r;
      tick(5);
      // R1 reset state
      chk("R1 codes after reset", codes, 16'h0000);
      chk("R1 pull after reset", sda_pull, 1'b0);
      rst_n = 1'b1;
      tick(5);

      // table walk: R2 address, R3 ack, R4 channel write, R7 clear
      for (int v = 0; v < 8; v++) begin
         logic [47:0] e;
         e = VEC[v];
         bus_start();
         send_byte(e[47:40], a, r);
         chk($sformatf("R2 addr ack vec%0d", v), a, e[0]);
         chk($sformatf("R3 release vec%0d", v), r, 1'b1);
         send_byte(e[39:32], a, r);
         chk($sformatf("R3 cmd ack vec%0d", v), a, e[0]);
         send_byte(e[31:24], a, r);
         chk($sformatf("R3 data ack vec%0d", v), a, e[0]);
         bus_stop();
         tick(4);
         chk($sformatf("R4 R7 codes vec%0d", v), codes, {e[15:8], e[23:16]});
      end

      // R5 hold: stage only
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h08, a, r);
      send_byte(8'h11, a, r);
      bus_stop(); tick(4);
      chk("R5 staged code not shown", codes, 16'h00FF);

      // R6 lone transfer command
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h02, a, r);
      chk("R6 lone cmd ack", a, 1'b1);
      bus_stop(); tick(4);
      chk("R6 transfer all", codes, 16'h0011);

      // R8 two pairs in one transfer
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h00, a, r);
      send_byte(8'h21, a, r);
      send_byte(8'h01, a, r);
      send_byte(8'h42, a, r);
      chk("R8 second data ack", a, 1'b1);
      bus_stop(); tick(4);
      chk("R8 both pairs", codes, 16'h4221);

      // R9 stop in mid byte
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h00, a, r);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_stop(); tick(4);
      chk("R9 partial byte dropped", codes, 16'h4221);
      chk("R9 pull released", sda_pull, 1'b0);

      // R10 repeated start inside a byte
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h01, a, r);
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      bus_start();
      send_byte(ADDR_OK, a, r);
      chk("R10 addr ack after restart", a, 1'b1);
      send_byte(8'h00, a, r);
      send_byte(8'h99, a, r);
      bus_stop(); tick(4);
      chk("R10 restart mid byte", codes, 16'h4299);

      // R10 restart after ignored address
      bus_start();
      send_byte(8'h4E, a, r);
      chk("R2 wrong pins no ack", a, 1'b0);
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h01, a, r);
      send_byte(8'h5A, a, r);
      bus_stop(); tick(4);
      chk("R10 restart after skip", codes, 16'h5A99);

      // R7 clear combined with a write to channel 1
      bus_start();
      send_byte(ADDR_OK, a, r);
      send_byte(8'h11, a, r);
      send_byte(8'h33, a, r);
      bus_stop(); tick(4);
      chk("R7 clear then write ch1", codes, 16'h3300);

      // R1 reset during operation
      rst_n = 1'b0; tick(3);
      chk("R1 codes after second reset", codes, 16'h0000);
      chk("R1 pull after second reset", sda_pull, 1'b0);
      rst_n = 1'b1; tick(3);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule